// File: doc/BRIEF.md
# GPIO Edge Event Status Unit

This block watches a bank of general-purpose input pins for transitions and files each transition into one of two status sets. One set holds "assert" events and the other holds "deassert" events. A per-pin polarity bit chooses which direction of transition counts as the assert event, and the opposite transition is filed as the deassert event. A per-pin enable bit decides whether a pin records anything at all. Each status set drives its own level interrupt line. A line stays high while any bit in its set is 1.

Software reaches the block through a simple synchronous register port: a write strobe, a six-bit word address, write data and combinational read data. The enable and polarity words pack 32 pins per word. The status words pack only 31 pins per word, because bit 0 of every status write is a mode bit. That bit decides whether the 1s in the rest of the word set or clear status bits. Software can therefore acknowledge events, and it can also inject them for testing, without a read-modify-write.

Pins are brought into the clock domain through a synchronizer. Edges are found by comparing the synchronized value with the value sampled one cycle earlier.

Top module: `gpio_evt_unit`

## Requirements
- R1: Address `{region[1:0], index[3:0]}` selects a word. Region 0 is enable and region 1 is polarity. In both, pin n sits at word n/32, bit n%32. A write replaces the whole word. A read returns the stored bits, with 0 for bit positions that have no pin.
- R2: Region 2 is the assert status set and region 3 is the deassert status set. In both, pin n sits at word n/31, bit (n%31)+1. Bit 0 reads 0, and bit positions that have no pin read 0. Unmapped words read 0.
- R3: With polarity 1, a rising transition sets the pin's assert status bit, and a falling transition sets its deassert status bit.
- R4: With polarity 0, a falling transition sets the pin's assert status bit, and a rising transition sets its deassert status bit.
- R5: A pin whose enable bit is 0 records no event in either set.
- R6: A status write with bit 0 = 0 clears every status bit whose position holds a 1 in bits 31..1. Other bits are unchanged.
- R7: A status write with bit 0 = 1 sets every status bit whose position holds a 1 in bits 31..1. Other bits are unchanged.
- R8: `irq_assert_o` is high exactly when some assert status bit is 1, and `irq_deassert_o` is high exactly when some deassert status bit is 1. Both stay high until software clears the bits.
- R9: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up 1.
- R10: With the default two synchronizer stages, a pin change made before rising edge k shows in status and interrupt after edge k+2, and not before.
- R11: After reset, all enable, polarity and status bits are 0 and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Word address: region in [5:4], word index in [3:0] |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_assert_o | output | 1 | Level interrupt, OR of the assert status set |
| irq_deassert_o | output | 1 | Level interrupt, OR of the deassert status set |

## Verification
The bench targets the packing seam between the 32-per-word control layout and the 31-per-word status layout, using pins 30, 31, 32 and 39. A design that shared one packing for both would put those events in the wrong word or bit, or would let a write reach bit 0. The bench also lines up a clearing write with an event arriving on the same bit in the same cycle. A design that gave priority to the write would lose that event. The bench counts exact latency in cycles, so an extra or missing register stage shows up. It toggles a disabled pin and flips polarity to catch swapped assert and deassert sets. It also writes 1s into positions that have no pin, so any phantom storage at those positions would show up on readback.

// File: rtl/gpio_evt_pkg.sv
// Shared constants and the region encoding for the GPIO edge event unit.
// Assumes at most 16 words per region (NUM_PINS <= 496).
package gpio_evt_pkg;
    localparam int CTRL_BITS = 32;   // pins per enable/polarity word
    localparam int STAT_BITS = 31;   // pins per status word (bit 0 is the mode bit)
    localparam int IDX_W     = 4;
    localparam int ADDR_W    = 6;

    typedef enum logic [1:0] {
        RGN_ENABLE   = 2'd0,
        RGN_POLARITY = 2'd1,
        RGN_ASSERT   = 2'd2,
        RGN_DEASSERT = 2'd3
    } region_e;
endpackage

// File: rtl/gpio_evt_edge.sv
// Synchronizes the pin vector and turns transitions into assert/deassert
// event pulses of one cycle, gated by enable and steered by polarity.
// Assumes the sampled state resets to 0, so a pin that is high out of reset
// looks like a rising edge. Enables reset to 0, so nothing is filed.
module gpio_evt_edge #(
    parameter int NUM_PINS    = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] en_i,
    input  logic [NUM_PINS-1:0] pol_i,
    output logic [NUM_PINS-1:0] asrt_evt_o,
    output logic [NUM_PINS-1:0] dsrt_evt_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [NUM_PINS-1:0] sync_q [SYNC_STAGES];
    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] rise, fall;

    // Synchronizer chain plus one-cycle history of the synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= pin_i;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
            prev_q <= sync_q[LAST];
        end
    end

    // Edge classification by polarity, suppressed for disabled pins.
    always_comb begin
        rise       = sync_q[LAST] & ~prev_q;
        fall       = ~sync_q[LAST] & prev_q;
        asrt_evt_o = en_i & ((pol_i & rise) | (~pol_i & fall));
        dsrt_evt_o = en_i & ((pol_i & fall) | (~pol_i & rise));
    end
endmodule

// File: rtl/gpio_evt_ctrl_regs.sv
// Enable and polarity storage, 32 pins per word, whole-word writes.
// Assumes writes are already qualified by region in the parent.
module gpio_evt_ctrl_regs
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_wr_i,
    input  logic                pol_wr_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [31:0]         wdata_i,
    input  logic                rd_pol_i,
    output logic [NUM_PINS-1:0] en_o,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [31:0]         rd_o
);
    logic [NUM_PINS-1:0] en_q, pol_q, en_d, pol_d;

    // Next-state: replace the bits of the addressed word.
    always_comb begin
        en_d  = en_q;
        pol_d = pol_q;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(idx_i) == p / CTRL_BITS) begin
                if (en_wr_i)  en_d[p]  = wdata_i[p % CTRL_BITS];
                if (pol_wr_i) pol_d[p] = wdata_i[p % CTRL_BITS];
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
        end else begin
            en_q  <= en_d;
            pol_q <= pol_d;
        end
    end

    // Readback of the addressed word; absent pins read 0.
    always_comb begin
        rd_o = '0;
        for (int b = 0; b < CTRL_BITS; b++) begin
            if (int'(idx_i) * CTRL_BITS + b < NUM_PINS)
                rd_o[b] = rd_pol_i ? pol_q[int'(idx_i) * CTRL_BITS + b]
                                   : en_q[int'(idx_i) * CTRL_BITS + b];
        end
    end

    assign en_o  = en_q;
    assign pol_o = pol_q;

    // R1
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_wr_i && !pol_wr_i) |=> ($stable(en_q) && $stable(pol_q)));
endmodule

// File: rtl/gpio_evt_status_bank.sv
// One status set: 31 pins per word, bit 0 of a write selects set (1) or
// clear (0). Hardware events override a clear in the same cycle. The
// interrupt is the OR of all stored bits.
// Assumes wr_i is already qualified by region in the parent.
module gpio_evt_status_bank
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [31:0]         wdata_i,
    input  logic [NUM_PINS-1:0] evt_i,
    output logic [31:0]         rd_o,
    output logic                irq_o
);
    logic [NUM_PINS-1:0] stat_q, stat_d;

    // Next-state: software set/clear on the addressed word, then OR in events.
    always_comb begin
        stat_d = stat_q;
        if (wr_i) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (int'(idx_i) == p / STAT_BITS && wdata_i[p % STAT_BITS + 1])
                    stat_d[p] = wdata_i[0];
            end
        end
        stat_d = stat_d | evt_i;
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // Readback with bit 0 held at 0 and absent pins reading 0.
    always_comb begin
        rd_o = '0;
        for (int b = 1; b <= STAT_BITS; b++) begin
            if (int'(idx_i) * STAT_BITS + b - 1 < NUM_PINS)
                rd_o[b] = stat_q[int'(idx_i) * STAT_BITS + b - 1];
        end
    end

    // Level interrupt.
    assign irq_o = |stat_q;

    // R9
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
    // R8
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/gpio_evt_unit.sv
// Top of the GPIO edge event unit: decodes the register port, holds the
// control words, detects edges and keeps the assert and deassert status sets.
// Assumes a single-cycle write strobe and combinational reads.
module gpio_evt_unit
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS    = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic                irq_assert_o,
    output logic                irq_deassert_o
);
    region_e             region;
    logic [IDX_W-1:0]    idx;
    logic [NUM_PINS-1:0] en_vec, pol_vec, asrt_evt, dsrt_evt;
    logic [31:0]         ctrl_rd;
    logic [NUM_PINS-1:0] evt_arr [2];
    logic [31:0]         stat_rd [2];
    logic [1:0]          bank_wr, bank_irq;

    // Address split into region and word index.
    assign region = region_e'(bus_addr_i[ADDR_W-1 -: 2]);
    assign idx    = bus_addr_i[IDX_W-1:0];

    gpio_evt_ctrl_regs #(.NUM_PINS(NUM_PINS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr_i  (bus_wr_i && region == RGN_ENABLE),
        .pol_wr_i (bus_wr_i && region == RGN_POLARITY),
        .idx_i    (idx),
        .wdata_i  (bus_wdata_i),
        .rd_pol_i (region == RGN_POLARITY),
        .en_o     (en_vec),
        .pol_o    (pol_vec),
        .rd_o     (ctrl_rd)
    );

    gpio_evt_edge #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .en_i       (en_vec),
        .pol_i      (pol_vec),
        .asrt_evt_o (asrt_evt),
        .dsrt_evt_o (dsrt_evt)
    );

    // Routing of event vectors and write strobes to the two status sets.
    assign evt_arr[0] = asrt_evt;
    assign evt_arr[1] = dsrt_evt;
    assign bank_wr[0] = bus_wr_i && region == RGN_ASSERT;
    assign bank_wr[1] = bus_wr_i && region == RGN_DEASSERT;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        gpio_evt_status_bank #(.NUM_PINS(NUM_PINS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (bank_wr[g]),
            .idx_i   (idx),
            .wdata_i (bus_wdata_i),
            .evt_i   (evt_arr[g]),
            .rd_o    (stat_rd[g]),
            .irq_o   (bank_irq[g])
        );
    end

    // Read data multiplexer by region.
    always_comb begin
        unique case (region)
            RGN_ASSERT:   bus_rdata_o = stat_rd[0];
            RGN_DEASSERT: bus_rdata_o = stat_rd[1];
            default:      bus_rdata_o = ctrl_rd;
        endcase
    end

    assign irq_assert_o   = bank_irq[0];
    assign irq_deassert_o = bank_irq[1];

    // R5
    evt_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((asrt_evt | dsrt_evt) & ~en_vec) == '0);
    // R3
    evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asrt_evt & dsrt_evt) == '0);
    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_assert_o && !bus_wr_i) |=> irq_assert_o);
    // R2
    stat_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_i[ADDR_W-1] |-> !bus_rdata_o[0]);
endmodule

// File: tb/tb_gpio_evt_unit.sv
`timescale 1ns/100ps
module tb_gpio_evt_unit;
    localparam int NP = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          bus_wr = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_a, irq_d;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        bit          is_irq;
        logic [5:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    event  chk_ev;

    always #2.5 clk = ~clk;

    gpio_evt_unit #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_assert_o(irq_a), .irq_deassert_o(irq_d)
    );

    // Addresses computed from the requirement packing.
    function automatic logic [5:0] a_en(int w);  return {2'd0, 4'(w)}; endfunction
    function automatic logic [5:0] a_pol(int w); return {2'd1, 4'(w)}; endfunction
    function automatic logic [5:0] a_ast(int w); return {2'd2, 4'(w)}; endfunction
    function automatic logic [5:0] a_dst(int w); return {2'd3, 4'(w)}; endfunction
    function automatic logic [31:0] sbit(int p); return 32'd1 << (p % 31 + 1); endfunction

    // Monitor: pops expected items and compares with the design outputs.
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_irq ? {30'd0, irq_d, irq_a} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s addr=%h actual=%h expected=%h",
                             it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic bus_write(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_read(logic [5:0] a, logic [31:0] e, string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.is_irq = 0; it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        -> chk_ev;
        #1.5;
    endtask

    task automatic expect_irq(logic [1:0] e, string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1; it.addr = '0; it.exp = {30'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        -> chk_ev;
        #1.5;
    endtask

    task automatic drive_pin(int p, logic v);
        @(negedge clk);
        pins[p] = v;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        expect_read(a_en(0),  32'h0, "R11 enable reset");
        expect_read(a_pol(0), 32'h0, "R11 polarity reset");
        expect_read(a_ast(0), 32'h0, "R11 assert status reset");
        expect_read(a_dst(1), 32'h0, "R11 deassert status reset");
        expect_irq(2'b00, "R11 irq reset");

        // R1: packing and readback of control words
        bus_write(a_pol(0), 32'hA5A5_0F0F);
        expect_read(a_pol(0), 32'hA5A5_0F0F, "R1 polarity readback");
        bus_write(a_en(1), 32'hFFFF_FFFF);
        expect_read(a_en(1), 32'h0000_00FF, "R1 enable word1 absent bits");
        expect_read(a_en(5), 32'h0, "R2 unmapped word");
        bus_write(a_en(0), ~(32'd1 << 5));
        bus_write(a_pol(0), 32'hFFFF_FFFF);
        bus_write(a_pol(1), 32'h0);
        expect_read(a_en(0), 32'hFFFF_FFDF, "R1 enable word0");

        // R10 + R3: exact latency of a rising edge on pin 0
        @(negedge clk);
        pins[0] = 1'b1;
        expect_read(a_ast(0), 32'h0, "R10 not after first edge");
        expect_read(a_ast(0), 32'h0, "R10 not after second edge");
        expect_read(a_ast(0), sbit(0), "R10 R3 set after third edge");
        expect_irq(2'b01, "R8 assert irq");
        drive_pin(0, 1'b0);
        expect_read(a_dst(0), sbit(0), "R3 falling edge deassert");
        expect_irq(2'b11, "R8 both irqs");

        // R6: clear acknowledges
        bus_write(a_ast(0), sbit(0));
        expect_read(a_ast(0), 32'h0, "R6 clear assert");
        expect_irq(2'b10, "R8 assert irq drops after clear");
        bus_write(a_dst(0), sbit(0));
        expect_irq(2'b00, "R8 both irqs low");

        // R4: polarity 0 on pin 32
        drive_pin(32, 1'b1);
        expect_read(a_dst(1), sbit(32), "R4 rising is deassert");
        expect_read(a_ast(1), 32'h0, "R4 no assert on rise");
        drive_pin(32, 1'b0);
        expect_read(a_ast(1), sbit(32), "R4 falling is assert");
        bus_write(a_ast(1), sbit(32));
        bus_write(a_dst(1), sbit(32));
        expect_read(a_dst(1), 32'h0, "R6 clear deassert word1");

        // R5: disabled pin 5
        drive_pin(5, 1'b1);
        drive_pin(5, 1'b0);
        expect_read(a_ast(0), 32'h0, "R5 disabled pin no assert");
        expect_read(a_dst(0), 32'h0, "R5 disabled pin no deassert");
        expect_irq(2'b00, "R5 no irq");

        // R2: boundary pins 30, 31, 39
        drive_pin(30, 1'b1);
        expect_read(a_ast(0), 32'h8000_0000, "R2 pin30 top bit of word0");
        drive_pin(31, 1'b1);
        expect_read(a_ast(1), 32'h0000_0002, "R2 pin31 bit1 of word1");
        drive_pin(39, 1'b1);
        expect_read(a_dst(1), 32'h0000_0200, "R2 pin39 bit9 of word1");
        bus_write(a_ast(0), 32'hFFFF_FFFE);
        bus_write(a_ast(1), 32'hFFFF_FFFE);
        bus_write(a_dst(1), 32'hFFFF_FFFE);
        expect_read(a_ast(1), 32'h0, "R6 clear all word1");
        expect_irq(2'b00, "R6 irqs clear");

        // R7: software set, absent positions ignored
        bus_write(a_ast(0), 32'h0000_0011);
        expect_read(a_ast(0), 32'h0000_0010, "R7 set pin3");
        bus_write(a_ast(1), 32'hFFFF_FFFF);
        expect_read(a_ast(1), 32'h0000_03FE, "R7 R2 set only existing pins");
        repeat (6) @(negedge clk);
        expect_irq(2'b01, "R8 irq held while idle");
        bus_write(a_ast(0), 32'h0000_0010);
        expect_read(a_ast(0), 32'h0, "R6 clear leaves others");
        expect_read(a_ast(1), 32'h0000_03FE, "R6 other word untouched");
        bus_write(a_ast(1), 32'h0000_03FE);
        expect_irq(2'b00, "R8 irq low after full clear");

        // R9: event and clear hit pin 1 in the same cycle
        @(negedge clk);
        pins[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = a_ast(0); bus_wdata = 32'hFFFF_FFFE; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        expect_read(a_ast(0), sbit(1), "R9 event wins over clear");
        expect_irq(2'b01, "R9 irq from surviving event");
        bus_write(a_ast(0), sbit(1));
        expect_read(a_ast(0), 32'h0, "R9 later clear works");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule